// File: doc/BRIEF.md
# Periodic System Tick Timer

This block is a memory-mapped periodic timer built around a down-counter, 24 bits wide by default. Software loads a period into the reload register and sets the enable bit. From then on the counter steps down once per selected tick. When the count reaches zero, the next step reloads it from the reload register. Each step from one to zero sets a sticky count flag, and when the interrupt bit is set it also pulses a tick interrupt request for one cycle.

The count source is chosen by a control bit. With the bit set, the counter steps on every processor clock. With the bit clear, it steps only in cycles where an external reference tick enable is high. A debug-halt input freezes the counter. Any write to the current-value register sets the count and the flag to zero and raises no interrupt.

The registers are reached through a single-cycle word port. A read returns data in the same cycle through a combinational path. A write takes effect at the next clock edge.

Top module: `tick_timer`

## Requirements
- R1: After reset the control/status word (offset 0x0), the reload word (0x4) and the current-value word (0x8) all read 0, the calibration word (0xC) reads 0xC0000000, and tick_irq is low.
- R2: With control bit 0 (enable) and bit 2 (clock source = processor clock) both set, the count drops by one on every clock. A step taken at a count of 0 loads the reload value instead.
- R3: With bit 2 clear, the counter steps only in cycles where ref_tick is high. It holds its value in all other cycles.
- R4: Control/status bit 16 is the count flag. It is set by a step from 1 to 0 and is returned by a control/status read, which clears it. If that read falls in the same cycle as a 1-to-0 step, the flag stays set.
- R5: A write of any value to offset 0x8 makes the count 0 and clears the flag at the next edge. This write never raises tick_irq.
- R6: When control bit 1 is set, each step from 1 to 0 drives tick_irq high for exactly the one cycle that follows. When bit 1 is clear, tick_irq stays low.
- R7: Writing 0 to the reload register stops the counter at 0 after its next wrap. Writing a non-zero reload afterwards restarts counting.
- R8: While dbg_halt is high, the count does not change.
- R9: The reload and count registers keep only bits [23:0]. Their bits [31:24] read 0. Control/status bits [31:17] and [15:3] read 0, and writes to them are ignored.
- R10: The calibration word ignores writes. Reads of offsets 0x10 and above return 0.
- R11: While control bit 0 is clear, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the read |
| ref_tick | input | 1 | External reference step enable |
| dbg_halt | input | 1 | Freezes the counter while high |
| tick_irq | output | 1 | One-cycle tick interrupt request |

## Verification
The bound checker covers the invariants on every cycle. A current-value write leaves a zero count, a clear flag and no interrupt. Halt and a clear enable both freeze the count. The flag can rise only onto a zero count, and each interrupt pulse lasts one cycle. Reserved, upper and unmapped read bits are always zero. Only the directed scenarios can show the exact sequence of values: the reload on wrap, the period length, stepping only on ref_tick, the flag winning when a status read collides with the 1-to-0 step, the stop after a zero reload and the restart that follows.

// File: rtl/tick_pkg.sv
package tick_pkg;
   localparam int DATA_W   = 32;
   localparam int EN_BIT   = 0;
   localparam int INT_BIT  = 1;
   localparam int SRC_BIT  = 2;
   localparam int FLAG_BIT = 16;

   // word index of each register (byte offset / 4)
   localparam logic [1:0] WORD_CTRL   = 2'd0;
   localparam logic [1:0] WORD_RELOAD = 2'd1;
   localparam logic [1:0] WORD_COUNT  = 2'd2;
   localparam logic [1:0] WORD_CALIB  = 2'd3;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_RELOAD,
      SEL_COUNT,
      SEL_CALIB
   } reg_sel_e;
endpackage

// File: rtl/tick_decode.sv
module tick_decode
   import tick_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   logic       hi_zero;
   logic [1:0] word;
   logic       unused_lsb;

   assign word       = addr[3:2];
   assign unused_lsb = ^addr[1:0];

   generate
      if (ADDR_W > 4) begin : g_hi
         assign hi_zero = (addr[ADDR_W-1:4] == '0);
      end else begin : g_nohi
         assign hi_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      sel = SEL_NONE;
      if (hi_zero) begin
         unique case (word)
            WORD_CTRL:   sel = SEL_CTRL;
            WORD_RELOAD: sel = SEL_RELOAD;
            WORD_COUNT:  sel = SEL_COUNT;
            default:     sel = SEL_CALIB;
         endcase
      end
   end
endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl
   import tick_pkg::*;
#(
   parameter int CNT_W       = 24,
   parameter bit HAS_EXT_REF = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctrl,
   input  logic             wr_reload,
   input  logic [2:0]       ctrl_wdata,
   input  logic [CNT_W-1:0] reload_wdata,
   output logic             enable,
   output logic             tickint,
   output logic             clk_src,
   output logic [CNT_W-1:0] reload
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable  <= 1'b0;
         tickint <= 1'b0;
         reload  <= '0;
      end else begin
         if (wr_ctrl) begin
            enable  <= ctrl_wdata[EN_BIT];
            tickint <= ctrl_wdata[INT_BIT];
         end
         if (wr_reload) reload <= reload_wdata;
      end
   end

   generate
      if (HAS_EXT_REF) begin : g_src_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       clk_src <= 1'b0;
            else if (wr_ctrl) clk_src <= ctrl_wdata[SRC_BIT];
         end
      end else begin : g_src_fixed
         logic unused_src;
         assign unused_src = ctrl_wdata[SRC_BIT];
         assign clk_src    = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/tick_core.sv
module tick_core #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             clk_src,
   input  logic             ref_tick,
   input  logic             dbg_halt,
   input  logic             tickint,
   input  logic [CNT_W-1:0] reload,
   input  logic             count_clr,
   input  logic             status_rd,
   output logic [CNT_W-1:0] count,
   output logic             flag,
   output logic             irq
);
   logic step;
   logic hit;

   assign step = enable & ~dbg_halt & (clk_src | ref_tick);
   assign hit  = step & (count == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         flag  <= 1'b0;
         irq   <= 1'b0;
      end else if (count_clr) begin
         count <= '0;
         flag  <= 1'b0;
         irq   <= 1'b0;
      end else begin
         if (step) count <= (count == '0) ? reload : count - CNT_W'(1);
         // setting wins over a clearing read in the same cycle
         if (hit)            flag <= 1'b1;
         else if (status_rd) flag <= 1'b0;
         irq <= hit & tickint;
      end
   end
endmodule

// File: rtl/tick_rdmux.sv
module tick_rdmux
   import tick_pkg::*;
#(
   parameter int               CNT_W     = 24,
   parameter logic [DATA_W-1:0] CALIB_VAL = 32'hC000_0000
) (
   input  reg_sel_e          sel,
   input  logic              rd_en,
   input  logic              enable,
   input  logic              tickint,
   input  logic              clk_src,
   input  logic              flag,
   input  logic [CNT_W-1:0]  reload,
   input  logic [CNT_W-1:0]  count,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] ctrl_word, reload_word, count_word;

   always_comb begin
      ctrl_word           = '0;
      ctrl_word[EN_BIT]   = enable;
      ctrl_word[INT_BIT]  = tickint;
      ctrl_word[SRC_BIT]  = clk_src;
      ctrl_word[FLAG_BIT] = flag;
      reload_word         = '0;
      reload_word[CNT_W-1:0] = reload;
      count_word          = '0;
      count_word[CNT_W-1:0]  = count;
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (sel)
            SEL_CTRL:   rdata = ctrl_word;
            SEL_RELOAD: rdata = reload_word;
            SEL_COUNT:  rdata = count_word;
            SEL_CALIB:  rdata = CALIB_VAL;
            default:    rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_pkg::*;
#(
   parameter int               CNT_W       = 24,
   parameter int               ADDR_W      = 6,
   parameter bit               HAS_EXT_REF = 1'b1,
   parameter logic [DATA_W-1:0] CALIB_VAL   = 32'hC000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ref_tick,
   input  logic              dbg_halt,
   output logic              tick_irq
);
   generate
      if (CNT_W < 2 || CNT_W >= FLAG_BIT && CNT_W > DATA_W) begin : g_bad_cnt
         $error("tick_timer: CNT_W out of range");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("tick_timer: ADDR_W must cover four word registers");
      end
   endgenerate

   reg_sel_e         sel;
   logic             wr_ctrl, wr_reload, wr_count, rd_ctrl, rd_en;
   logic             csr_en, csr_int, csr_src, flag_q;
   logic [CNT_W-1:0] reload_q, cnt_q;
   logic             unused_wdata;

   assign unused_wdata = ^bus_wdata;

   tick_decode #(.ADDR_W(ADDR_W)) dec_i (
      .addr (bus_addr),
      .sel  (sel)
   );

   assign wr_ctrl   = bus_sel &  bus_wr & (sel == SEL_CTRL);
   assign wr_reload = bus_sel &  bus_wr & (sel == SEL_RELOAD);
   assign wr_count  = bus_sel &  bus_wr & (sel == SEL_COUNT);
   assign rd_en     = bus_sel & ~bus_wr;
   assign rd_ctrl   = rd_en & (sel == SEL_CTRL);

   tick_ctrl #(.CNT_W(CNT_W), .HAS_EXT_REF(HAS_EXT_REF)) ctrl_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_ctrl      (wr_ctrl),
      .wr_reload    (wr_reload),
      .ctrl_wdata   (bus_wdata[2:0]),
      .reload_wdata (bus_wdata[CNT_W-1:0]),
      .enable       (csr_en),
      .tickint      (csr_int),
      .clk_src      (csr_src),
      .reload       (reload_q)
   );

   tick_core #(.CNT_W(CNT_W)) core_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (csr_en),
      .clk_src   (csr_src),
      .ref_tick  (ref_tick),
      .dbg_halt  (dbg_halt),
      .tickint   (csr_int),
      .reload    (reload_q),
      .count_clr (wr_count),
      .status_rd (rd_ctrl),
      .count     (cnt_q),
      .flag      (flag_q),
      .irq       (tick_irq)
   );

   tick_rdmux #(.CNT_W(CNT_W), .CALIB_VAL(CALIB_VAL)) rd_i (
      .sel     (sel),
      .rd_en   (rd_en),
      .enable  (csr_en),
      .tickint (csr_int),
      .clk_src (csr_src),
      .flag    (flag_q),
      .reload  (reload_q),
      .count   (cnt_q),
      .rdata   (bus_rdata)
   );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
   parameter int CNT_W  = 24,
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_rdata,
   input logic              dbg_halt,
   input logic              tick_irq,
   input logic [CNT_W-1:0]  count,
   input logic              flag,
   input logic              enable,
   input logic              tickint
);
   logic cnt_wr, ctrl_rd, any_rd, unmapped;

   assign any_rd   = bus_sel & ~bus_wr;
   assign cnt_wr   = bus_sel & bus_wr & (bus_addr == ADDR_W'(8));
   assign ctrl_rd  = any_rd & (bus_addr == ADDR_W'(0));
   assign unmapped = (bus_addr >= ADDR_W'(16));

   p_count_wr_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (count == '0) && !flag && !tick_irq);

   p_halt_freezes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_halt && !cnt_wr |=> $stable(count));

   p_disabled_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !enable && !cnt_wr |=> $stable(count));

   p_flag_on_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> (count == '0));

   p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tick_irq |=> !tick_irq);

   p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tick_irq |-> (count == '0) && flag && $past(tickint));

   p_ctrl_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_rd |-> (bus_rdata[31:17] == '0) && (bus_rdata[15:3] == '0));

   p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      any_rd && (bus_addr == ADDR_W'(4) || bus_addr == ADDR_W'(8))
         |-> (bus_rdata[31:CNT_W] == '0));

   p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      any_rd && unmapped |-> (bus_rdata == '0));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .dbg_halt  (dbg_halt),
   .tick_irq  (tick_irq),
   .count     (cnt_q),
   .flag      (flag_q),
   .enable    (csr_en),
   .tickint   (csr_int)
);

// File: tb/tick_timer_tb_top.sv
`timescale 1ns/1ps
module tick_timer_tb_top;
   localparam logic [5:0] A_CTRL = 6'h00, A_RLD = 6'h04, A_CNT = 6'h08, A_CAL = 6'h0C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        ref_tick = 1'b0, dbg_halt = 1'b0;
   logic        tick_irq;
   int          total = 0, bad = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   tick_timer dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ref_tick(ref_tick), .dbg_halt(dbg_halt), .tick_irq(tick_irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 check(req, bus_rdata, exp);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic setup(input logic [31:0] rld);
      logic [31:0] dummy;
      wr(A_CTRL, 32'h0);
      wr(A_CNT, 32'h0);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_CTRL;
      #1 dummy = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
      wr(A_RLD, rld);
   endtask

   task automatic t_reset();
      rd_chk("R1 ctrl", A_CTRL, 32'h0);
      rd_chk("R1 reload", A_RLD, 32'h0);
      rd_chk("R1 count", A_CNT, 32'h0);
      rd_chk("R1 calib", A_CAL, 32'hC000_0000);
      check("R1 irq", {31'b0, tick_irq}, 32'h0);
   endtask

   task automatic t_periodic();
      logic [31:0] seq [8] = '{0, 5, 4, 3, 2, 1, 0, 5};
      setup(32'd5);
      wr(A_CTRL, 32'h5);
      for (int i = 0; i < 8; i++) begin
         check("R6 irq off", {31'b0, tick_irq}, 32'h0);
         rd_chk("R2 count sequence", A_CNT, seq[i]);
      end
      wr(A_CTRL, 32'h0);
   endtask

   task automatic t_flag();
      setup(32'd2);
      wr(A_CTRL, 32'h5);
      idle(2);
      rd_chk("R4 read in set cycle", A_CTRL, 32'h0000_0005);
      rd_chk("R4 flag kept", A_CTRL, 32'h0001_0005);
      rd_chk("R4 flag cleared by read", A_CTRL, 32'h0000_0005);
      wr(A_CTRL, 32'h0);
   endtask

   task automatic t_irq_and_clear();
      logic [31:0] irq_seq [6] = '{0, 0, 0, 0, 1, 0};
      setup(32'd3);
      wr(A_CTRL, 32'h7);
      for (int i = 0; i < 6; i++) begin
         #1 check("R6 irq pulse", {31'b0, tick_irq}, irq_seq[i]);
         @(negedge clk);
      end
      idle(1);
      wr(A_CNT, 32'hDEAD_BEEF);
      #1 check("R5 no irq after count write", {31'b0, tick_irq}, 32'h0);
      rd_chk("R5 count zeroed", A_CNT, 32'h0);
      rd_chk("R5 flag cleared", A_CTRL, 32'h0000_0007);
      wr(A_CTRL, 32'h0);
   endtask

   task automatic t_ext_ref();
      setup(32'd4);
      wr(A_CTRL, 32'h1);
      ref_tick = 1'b1;
      @(negedge clk);
      ref_tick = 1'b0;
      rd_chk("R3 loaded on ref", A_CNT, 32'd4);
      idle(2);
      rd_chk("R3 hold without ref", A_CNT, 32'd4);
      ref_tick = 1'b1;
      idle(2);
      ref_tick = 1'b0;
      rd_chk("R3 two ref steps", A_CNT, 32'd2);
      wr(A_CTRL, 32'h0);
   endtask

   task automatic t_zero_reload();
      setup(32'd3);
      wr(A_CTRL, 32'h5);
      idle(1);
      wr(A_RLD, 32'h0);
      idle(3);
      rd_chk("R7 stopped", A_CNT, 32'h0);
      rd_chk("R7 still stopped", A_CNT, 32'h0);
      wr(A_RLD, 32'd3);
      rd_chk("R7 before restart", A_CNT, 32'h0);
      rd_chk("R7 restarted", A_CNT, 32'd3);
      wr(A_CTRL, 32'h0);
   endtask

   task automatic t_halt_disable();
      setup(32'd10);
      wr(A_CTRL, 32'h5);
      idle(2);
      dbg_halt = 1'b1;
      idle(4);
      rd_chk("R8 frozen", A_CNT, 32'd9);
      dbg_halt = 1'b0;
      rd_chk("R8 released", A_CNT, 32'd9);
      rd_chk("R8 counting again", A_CNT, 32'd8);
      wr(A_CTRL, 32'h4);
      rd_chk("R11 disabled value", A_CNT, 32'd6);
      idle(3);
      rd_chk("R11 holds", A_CNT, 32'd6);
   endtask

   task automatic t_widths();
      setup(32'hFFAB_CDEF);
      rd_chk("R9 reload upper bits", A_RLD, 32'h00AB_CDEF);
      wr(A_CTRL, 32'hFFFF_FFF8);
      rd_chk("R9 reserved ctrl bits", A_CTRL, 32'h0);
   endtask

   task automatic t_calib_unmapped();
      wr(A_CAL, 32'h1234_5678);
      rd_chk("R10 calib read-only", A_CAL, 32'hC000_0000);
      rd_chk("R10 unmapped 0x10", 6'h10, 32'h0);
      rd_chk("R10 unmapped 0x3C", 6'h3C, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_periodic();
      t_flag();
      t_irq_and_clear();
      t_ext_ref();
      t_zero_reload();
      t_halt_disable();
      t_widths();
      t_calib_unmapped();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule